// File: doc/BRIEF.md
# Bridge Forwarding Decoder

This block makes the claim decision for a two-port bus bridge. For each transaction it takes the address, the command type and the side the transaction started on (primary or secondary). It then decides whether the bridge forwards the transaction to the other side, and in which direction. It also decides whether a read that is forwarded may prefetch.

The decision uses a set of configuration registers, written through a simple write port:
- an I/O window with 4 KB granularity;
- a non-prefetchable memory window with 1 MB granularity;
- a control word holding an I/O enable, a memory enable, a master enable and an ISA alias mode.

In ISA alias mode, each aligned 1 KB block below 64 KB is split. Only the low 256 bytes can go downstream. The upper 768 bytes go upstream. The decision is registered, so it appears one clock after the request is presented.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: After reset the control word is cleared, every window is disabled (base all ones, limit zero) and all outputs are low.
- R2: A request on `req_valid_i` produces its decision on `out_valid_o`, `fwd_o`, `dir_up_o` and `pref_ok_o` one clock later. A cycle without a request leaves all three decision outputs low one clock later. `dir_up_o` is high only for a forwarded request from the secondary side.
- R3: The I/O window covers byte addresses from base through limit plus 0xFFF inclusive. A limit below the base disables the window, so nothing is inside it.
- R4: A primary-side I/O command (0 = I/O read, 1 = I/O write) is forwarded downstream only when all three of these hold: the I/O enable (control bit 0) is set, the address is inside the I/O window, and the address is not in an ISA upper block.
- R5: With ISA mode (control bit 3) set, an I/O address below 0x10000 whose bits [9:8] are nonzero is an ISA upper block. Such an access is never forwarded from the primary side. From the secondary side it is forwarded upstream when the master enable is set.
- R6: An I/O address at or above 0x10000 is decoded only against the I/O window, whatever the ISA mode.
- R7: A secondary-side I/O access that is not an ISA upper block is forwarded upstream only when it is outside the I/O window and the master enable (control bit 2) is set.
- R8: The memory window covers base through limit plus 0xFFFFF inclusive, and a limit below the base disables it. A primary-side memory command (2 = read, 3 = read line, 4 = read multiple, 5 = write) inside the window is forwarded downstream when the memory enable (control bit 1) is set.
- R9: A secondary-side memory command is forwarded upstream when it is outside the memory window and the master enable is set. It is never forwarded when it is inside the window.
- R10: `pref_ok_o` is high only for a forwarded read line (3) or read multiple (4). A plain read (2) and a write are limited to a single data phase.
- R11: Command codes 6 and 7 are never forwarded.
- R12: A configuration write uses the field `cfg_wdata_i` and selects a register with `cfg_sel_i`:
  - `cfg_sel_i` 0 loads the I/O base and 1 loads the I/O limit, both from `cfg_wdata_i[31:12]`;
  - 2 loads the memory base and 3 loads the memory limit, both from `cfg_wdata_i[31:20]`;
  - 4 loads the control word from `cfg_wdata_i[3:0]`;
  - `cfg_sel_i` 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Transaction address valid |
| req_addr_i | input | 32 | Transaction address |
| req_cmd_i | input | 3 | Command code |
| req_side_i | input | 1 | Originating side, 0 primary, 1 secondary |
| out_valid_o | output | 1 | Decision valid, one clock after the request |
| fwd_o | output | 1 | Transaction is claimed and forwarded |
| dir_up_o | output | 1 | Forward direction is upstream |
| pref_ok_o | output | 1 | Forwarded read may prefetch |

## Verification
The assertions assume two things about the inputs. First, configuration writes do not happen in the same cycle as a request whose decision they would change. Second, `req_cmd_i` and `req_side_i` are stable while `req_valid_i` is sampled. The stimulus respects both: each configuration is written completely while no request is active, and only then is an address sweep run against it. Every request is driven away from the clock edge, and each request is held for exactly one cycle.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

  typedef enum logic [2:0] {
    CMD_IO_RD       = 3'd0,
    CMD_IO_WR       = 3'd1,
    CMD_MEM_RD      = 3'd2,
    CMD_MEM_RD_LINE = 3'd3,
    CMD_MEM_RD_MULT = 3'd4,
    CMD_MEM_WR      = 3'd5,
    CMD_RSV6        = 3'd6,
    CMD_RSV7        = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    SEL_IO_BASE   = 3'd0,
    SEL_IO_LIMIT  = 3'd1,
    SEL_MEM_BASE  = 3'd2,
    SEL_MEM_LIMIT = 3'd3,
    SEL_CTRL      = 3'd4,
    SEL_RSV5      = 3'd5,
    SEL_RSV6      = 3'd6,
    SEL_RSV7      = 3'd7
  } sel_e;

  typedef struct packed {
    logic isa_en;
    logic master_en;
    logic mem_en;
    logic io_en;
  } ctrl_t;

  typedef struct packed {
    logic fwd;
    logic dir_up;
    logic pref_ok;
  } dec_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bfd_cfg_regs.sv
module bfd_cfg_regs
  import bfd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IO_GRAN  = 12,
  parameter int unsigned MEM_GRAN = 20,
  localparam int unsigned IO_PW   = ADDR_W - IO_GRAN,
  localparam int unsigned MEM_PW  = ADDR_W - MEM_GRAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [IO_PW-1:0]  io_base_o,
  output logic [IO_PW-1:0]  io_limit_o,
  output logic [MEM_PW-1:0] mem_base_o,
  output logic [MEM_PW-1:0] mem_limit_o,
  output ctrl_t             ctrl_o
);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[IO_GRAN-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_base_o   <= '1;
      io_limit_o  <= '0;
      mem_base_o  <= '1;
      mem_limit_o <= '0;
      ctrl_o      <= '0;
    end else if (we_i) begin
      unique case (sel_e'(sel_i))
        SEL_IO_BASE:   io_base_o   <= wdata_i[ADDR_W-1:IO_GRAN];
        SEL_IO_LIMIT:  io_limit_o  <= wdata_i[ADDR_W-1:IO_GRAN];
        SEL_MEM_BASE:  mem_base_o  <= wdata_i[ADDR_W-1:MEM_GRAN];
        SEL_MEM_LIMIT: mem_limit_o <= wdata_i[ADDR_W-1:MEM_GRAN];
        SEL_CTRL:      ctrl_o      <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:       ;
      endcase
    end
  end

  // R12
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CTRL) |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0])));

  // R12
  rsv_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i > SEL_CTRL) |=> ($stable(ctrl_o) && $stable(io_base_o) && $stable(mem_limit_o)));

endmodule

// File: rtl/bfd_window.sv
module bfd_window #(
  parameter int unsigned PW = 20
) (
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] base_i,
  input  logic [PW-1:0] limit_i,
  output logic          hit_o
);

  logic enabled;
  assign enabled = (limit_i >= base_i);
  assign hit_o   = enabled && (page_i >= base_i) && (page_i <= limit_i);

endmodule

// File: rtl/bfd_io_dec.sv
module bfd_io_dec #(
  parameter int unsigned OFF_W = 2
) (
  input  logic             side_sec_i,
  input  logic             below_isa_top_i,
  input  logic [OFF_W-1:0] blk_off_i,
  input  logic             in_win_i,
  input  logic             io_en_i,
  input  logic             master_en_i,
  input  logic             isa_en_i,
  output logic             fwd_o
);

  logic isa_upper;
  // upper part of each 1KB block below the ISA boundary belongs upstream
  assign isa_upper = isa_en_i && below_isa_top_i && (blk_off_i != '0);

  always_comb begin
    if (side_sec_i) fwd_o = master_en_i && (isa_upper || !in_win_i);
    else            fwd_o = io_en_i && in_win_i && !isa_upper;
  end

endmodule

// File: rtl/bfd_mem_dec.sv
module bfd_mem_dec (
  input  logic side_sec_i,
  input  logic in_win_i,
  input  logic mem_en_i,
  input  logic master_en_i,
  output logic fwd_o
);

  always_comb begin
    if (side_sec_i) fwd_o = master_en_i && !in_win_i;
    else            fwd_o = mem_en_i && in_win_i;
  end

endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import bfd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IO_GRAN  = 12,
  parameter int unsigned MEM_GRAN = 20,
  parameter int unsigned ISA_TOP  = 16,
  parameter int unsigned ISA_BLK  = 10,
  parameter int unsigned ISA_LOW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_cmd_i,
  input  logic              req_side_i,
  output logic              out_valid_o,
  output logic              fwd_o,
  output logic              dir_up_o,
  output logic              pref_ok_o
);

  localparam int unsigned IO_PW  = ADDR_W - IO_GRAN;
  localparam int unsigned MEM_PW = ADDR_W - MEM_GRAN;
  localparam int unsigned OFF_W  = ISA_BLK - ISA_LOW;

  logic [IO_PW-1:0]  io_base, io_limit;
  logic [MEM_PW-1:0] mem_base, mem_limit;
  ctrl_t             ctrl;
  logic              io_hit, mem_hit, io_fwd, mem_fwd;
  logic              is_io, is_mem, is_pref_cmd;
  logic              below_isa_top;
  dec_t              dec;
  cmd_e              cmd;

  logic unused_addr;
  assign unused_addr = ^req_addr_i[ISA_LOW-1:0];

  bfd_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .IO_GRAN (IO_GRAN),
    .MEM_GRAN(MEM_GRAN)
  ) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .io_base_o  (io_base),
    .io_limit_o (io_limit),
    .mem_base_o (mem_base),
    .mem_limit_o(mem_limit),
    .ctrl_o     (ctrl)
  );

  bfd_window #(.PW(IO_PW)) io_win_i (
    .page_i (req_addr_i[ADDR_W-1:IO_GRAN]),
    .base_i (io_base),
    .limit_i(io_limit),
    .hit_o  (io_hit)
  );

  bfd_window #(.PW(MEM_PW)) mem_win_i (
    .page_i (req_addr_i[ADDR_W-1:MEM_GRAN]),
    .base_i (mem_base),
    .limit_i(mem_limit),
    .hit_o  (mem_hit)
  );

  assign below_isa_top = (req_addr_i[ADDR_W-1:ISA_TOP] == '0);

  bfd_io_dec #(.OFF_W(OFF_W)) io_dec_i (
    .side_sec_i     (req_side_i),
    .below_isa_top_i(below_isa_top),
    .blk_off_i      (req_addr_i[ISA_BLK-1:ISA_LOW]),
    .in_win_i       (io_hit),
    .io_en_i        (ctrl.io_en),
    .master_en_i    (ctrl.master_en),
    .isa_en_i       (ctrl.isa_en),
    .fwd_o          (io_fwd)
  );

  bfd_mem_dec mem_dec_i (
    .side_sec_i (req_side_i),
    .in_win_i   (mem_hit),
    .mem_en_i   (ctrl.mem_en),
    .master_en_i(ctrl.master_en),
    .fwd_o      (mem_fwd)
  );

  always_comb begin
    cmd         = cmd_e'(req_cmd_i);
    is_io       = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
    is_mem      = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_LINE) ||
                  (cmd == CMD_MEM_RD_MULT) || (cmd == CMD_MEM_WR);
    is_pref_cmd = (cmd == CMD_MEM_RD_LINE) || (cmd == CMD_MEM_RD_MULT);
    dec.fwd     = (is_io && io_fwd) || (is_mem && mem_fwd);
    dec.dir_up  = dec.fwd && req_side_i;
    dec.pref_ok = dec.fwd && is_pref_cmd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      fwd_o       <= 1'b0;
      dir_up_o    <= 1'b0;
      pref_ok_o   <= 1'b0;
    end else begin
      out_valid_o <= req_valid_i;
      fwd_o       <= req_valid_i && dec.fwd;
      dir_up_o    <= req_valid_i && dec.dir_up;
      pref_ok_o   <= req_valid_i && dec.pref_ok;
    end
  end

  // R2
  fwd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> out_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(fwd_o || dir_up_o || pref_ok_o));

  // R2
  dir_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_side_i) |=> !dir_up_o);

  // R10
  pref_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pref_ok_o |-> fwd_o);

  // R5
  isa_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_side_i && ctrl.isa_en && req_cmd_i <= CMD_IO_WR &&
     req_addr_i[ADDR_W-1:ISA_TOP] == '0 && req_addr_i[ISA_BLK-1:ISA_LOW] != '0) |=> !fwd_o);

  // R11
  rsv_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cmd_i >= CMD_RSV6) |=> !fwd_o);

  // R7
  up_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ctrl.master_en) |=> !dir_up_o);

endmodule

// File: tb/bridge_fwd_decoder_tb_top.sv
`timescale 1ns/1ps
module bridge_fwd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_cmd = '0;
  logic        req_side = 1'b0;
  logic        out_valid, fwd, dir_up, pref_ok;

  int n_chk = 0;
  int n_fail = 0;

  // bench copy of configuration
  longint io_lo, io_hi, mem_lo, mem_hi;
  bit     io_on, mem_on;
  bit     c_io, c_mem, c_mst, c_isa;

  always #5 clk = ~clk;

  bridge_fwd_decoder dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_sel_i  (cfg_sel),
    .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid),
    .req_addr_i (req_addr),
    .req_cmd_i  (req_cmd),
    .req_side_i (req_side),
    .out_valid_o(out_valid),
    .fwd_o      (fwd),
    .dir_up_o   (dir_up),
    .pref_ok_o  (pref_ok)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got {valid,fwd,up,pref}=%b expected %b (addr=%h cmd=%0d side=%0d)",
               tag, got, exp, req_addr, req_cmd, req_side);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input longint iob, input longint iol, input longint mb, input longint ml,
                         input bit io_e, input bit mem_e, input bit mst_e, input bit isa_e);
    wr(3'd0, iob[31:0]); wr(3'd1, iol[31:0]);
    wr(3'd2, mb[31:0]);  wr(3'd3, ml[31:0]);
    wr(3'd4, {28'd0, isa_e, mst_e, mem_e, io_e});
    io_lo = (iob / 4096) * 4096;   io_hi = (iol / 4096) * 4096 + 4095;
    mem_lo = (mb / 1048576) * 1048576; mem_hi = (ml / 1048576) * 1048576 + 1048575;
    io_on = (iol / 4096) >= (iob / 4096);
    mem_on = (ml / 1048576) >= (mb / 1048576);
    c_io = io_e; c_mem = mem_e; c_mst = mst_e; c_isa = isa_e;
  endtask

  function automatic logic [2:0] model(input longint a, input int cmd, input bit sec);
    bit f, in_w, isa_up;
    f = 1'b0;
    if (cmd <= 1) begin
      in_w   = io_on && a >= io_lo && a <= io_hi;
      isa_up = c_isa && a < 65536 && (a % 1024) >= 256;
      f = sec ? (c_mst && (isa_up || !in_w)) : (c_io && in_w && !isa_up);
    end else if (cmd <= 5) begin
      in_w = mem_on && a >= mem_lo && a <= mem_hi;
      f = sec ? (c_mst && !in_w) : (c_mem && in_w);
    end
    return {f, f && sec, f && (cmd == 3 || cmd == 4)};
  endfunction

  function automatic string tag_of(input longint a, input int cmd, input bit sec);
    if (cmd >= 6) return "R11";
    if (cmd <= 1) begin
      if (c_isa && a < 65536 && (a % 1024) >= 256) return "R5";
      if (a >= 65536) return "R6";
      return sec ? "R7" : "R4";
    end
    if (cmd == 3 || cmd == 4 || cmd == 2) return sec ? "R9/R10" : "R8/R10";
    return sec ? "R9" : "R8";
  endfunction

  task automatic req(input longint a, input int cmd, input bit sec, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[31:0]; req_cmd = cmd[2:0]; req_side = sec;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {out_valid, fwd, dir_up, pref_ok}, {1'b1, model(a, cmd, sec)});
  endtask

  task automatic sweep_io();
    for (int i = 0; i < 512; i++) begin
      longint a;
      a = longint'(i) * 256 + ((i % 3) * 68);
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 2; s++)
          req(a, c, s[0], tag_of(a, c, s[0]));
    end
  endtask

  task automatic sweep_mem();
    for (int p = 0; p < 17; p++) begin
      longint a;
      a = (p == 16) ? 64'hFFF0_1234 : longint'(p) * 1048576 + 20'hABC40 * (p % 2);
      for (int c = 2; c < 8; c++)
        for (int s = 0; s < 2; s++)
          req(a, c, s[0], tag_of(a, c, s[0]));
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    io_lo = 0; io_hi = 0; mem_lo = 0; mem_hi = 0;
    io_on = 0; mem_on = 0; c_io = 0; c_mem = 0; c_mst = 0; c_isa = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    chk("R1", {out_valid, fwd, dir_up, pref_ok}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, fwd, dir_up, pref_ok}, 4'b0000);
    // R1: enables cleared after reset
    req(32'h0000_0000, 0, 1'b0, "R1");
    req(32'h0000_0000, 0, 1'b1, "R1");
    // R1: windows disabled after reset even with enables set (only ctrl written)
    wr(3'd4, 32'h0000_000F);
    c_io = 1; c_mem = 1; c_mst = 1; c_isa = 1;
    req(32'h0000_0000, 2, 1'b0, "R1");
    req(32'h0000_0000, 3, 1'b1, "R1");
    req(32'h0001_0000, 1, 1'b0, "R1");
    // R2: no request gives quiet outputs next cycle
    @(negedge clk);
    chk("R2", {out_valid, fwd, dir_up, pref_ok}, 4'b0000);
    // R12: reserved selects change nothing
    wr(3'd5, 32'h0000_0000); wr(3'd6, 32'h0000_0000); wr(3'd7, 32'h0000_0000);
    req(32'h0000_0000, 0, 1'b1, "R12");

    // I/O window 0x1000-0x2FFF
    set_cfg(32'h1000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 1, 1, 1, 0);
    // R3 boundaries
    req(32'h0000_0FFF, 0, 1'b0, "R3");
    req(32'h0000_1000, 0, 1'b0, "R3");
    req(32'h0000_2FFF, 1, 1'b0, "R3");
    req(32'h0000_3000, 1, 1'b0, "R3");
    req(32'h0000_2FFF, 0, 1'b1, "R3");
    sweep_io();
    set_cfg(32'h1000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 1, 1, 1, 1);
    sweep_io();
    // window above 64KB with ISA on
    set_cfg(32'h1_0000, 32'h1_0000, 32'h0040_0000, 32'h0070_0000, 1, 1, 1, 1);
    req(32'h0001_0300, 0, 1'b0, "R6");
    req(32'h0001_0FFF, 0, 1'b0, "R6");
    sweep_io();
    // R3: disabled window, master off
    set_cfg(32'h3000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 1, 1, 0, 1);
    req(32'h0000_2000, 0, 1'b0, "R3");
    sweep_io();
    // io enable off
    set_cfg(32'h1000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 0, 1, 1, 0);
    sweep_io();

    // memory window 0x400000-0x7FFFFF
    set_cfg(32'h1000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 1, 1, 1, 0);
    req(32'h003F_FFFF, 2, 1'b0, "R8");
    req(32'h0040_0000, 3, 1'b0, "R8/R10");
    req(32'h007F_FFFF, 4, 1'b0, "R8/R10");
    req(32'h0080_0000, 4, 1'b1, "R9/R10");
    req(32'h0050_0000, 2, 1'b0, "R10");
    sweep_mem();
    set_cfg(32'h1000, 32'h2000, 32'h0040_0000, 32'h0070_0000, 1, 0, 0, 0);
    sweep_mem();
    set_cfg(32'h1000, 32'h2000, 32'h0080_0000, 32'h0030_0000, 1, 1, 1, 0);
    sweep_mem();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule